// File: doc/BRIEF.md
# Time-Shared Self-Checking Adder

This block adds two unsigned W-bit operands on a single ripple-carry adder, then reuses that same adder to check its own result. The check runs the inverse operation. The adder subtracts one operand from the sum, using one's complement of that operand plus a carry-in of 1. It then compares the difference with the other operand. A mismatch sets the error bit. The check can use either operand, or both checks can run one after the other. Because one adder does the work and the check, it models a system with limited resources. In such a system a fault in the shared hardware can hide itself, or can be caught even when the sum is correct.

Fault-injection inputs make any one full-adder cell of the chain misbehave. The fault is applied on every pass through the adder. The cell's sum output or carry output can be stuck at 0 or 1, or both outputs can come from a user-supplied truth table. A testbench can drive these inputs to measure how often faults are detected or masked. The block itself does not count coverage.

Operands enter through a valid/ready handshake. The input side applies back-pressure: `in_ready` is high only while the block is idle. The result side has no back-pressure. `done` pulses for one cycle, and `sum` and `err` then hold their values until the next operation is accepted.

Top module: `self_check_adder`

## Requirements
- R1: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when the block is idle. It is high after reset, low from the accept edge until the cycle after `done`, and high again after that.
- R2: With the fault disabled, `sum` equals (a + b) mod 2^W and `err` is 0 in every check mode. Carry-out of the addition is dropped and never counts as an error.
- R3: Check mode 2'b00 forms d = sum + ~a + 1 on the shared adder and sets `err` when d differs from b.
- R4: Check mode 2'b01 forms d = sum + ~b + 1 on the shared adder and sets `err` when d differs from a.
- R5: Check modes 2'b10 and 2'b11 run the R3 check and then the R4 check. `err` is the OR of the two results.
- R6: `done` is high for exactly one cycle. It rises 2 clock edges after the accept edge in modes 2'b00 and 2'b01, and 3 edges after it in modes 2'b10 and 2'b11.
- R7: `sum` and `err` are valid while `done` is high. They stay unchanged until the next accepted operation. Reset clears them to 0.
- R8: When `flt_en` is 1, only cell `flt_cell` misbehaves, where cell i produces sum bit i and carries into bit i+1. A `flt_cell` value of W or more, or `flt_en` = 0, leaves the adder fault-free.
- R9: `flt_kind` selects the faulty behaviour. 0 forces the cell's sum output to 0, and 1 forces it to 1. 2 forces the cell's carry output to 0, and 3 forces it to 1. With 4, the cell's sum output is `flt_tbl[{x,y,cin}]` and its carry output is `flt_tbl[8+{x,y,cin}]`, where x is the first adder input. Values 5 to 7 leave the cell fault-free.
- R10: The selected fault applies on every pass of an operation, both the addition and the checks. No logic hides its effect. The delivered `sum` and `err` are exactly those of the faulty adder, including masked faults with a wrong sum and `err` = 0, and detected faults with a correct sum and `err` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and check mode are offered |
| in_ready | output | 1 | Block is idle and accepts an operation |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| chk_mode | input | 2 | 00 subtract a, 01 subtract b, 1x both |
| flt_en | input | 1 | Enables the injected fault |
| flt_cell | input | IDXW | Index of the faulty full-adder cell |
| flt_kind | input | 3 | Faulty behaviour selector |
| flt_tbl | input | 16 | Truth table: sum in [7:0], carry in [15:8] |
| sum | output | W | Result of the addition |
| err | output | 1 | Check failure flag |
| done | output | 1 | One-cycle completion strobe |

## Verification
A wrong sequencer state shows up at the ports at once. It gives a `done` pulse at the wrong latency, a second `done` pulse, or `in_ready` staying low. An operand-mux error or a missing carry-in on a check pass sets `err` on fault-free operands, and this is seen in the same `done` cycle. A mistake in fault steering, such as the wrong cell, wrong kind decode, or a fault applied only on the add pass, makes `sum` or `err` differ from an independent bit-level model of the faulty adder. Random fault sweeps expose this within a few operations.

// File: rtl/sca_pkg.sv
package sca_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADD  = 3'd1,
    ST_CHKA = 3'd2,
    ST_CHKB = 3'd3,
    ST_DONE = 3'd4
  } sca_state_e;

  localparam logic [2:0] FK_SUM_LO = 3'd0;
  localparam logic [2:0] FK_SUM_HI = 3'd1;
  localparam logic [2:0] FK_CY_LO  = 3'd2;
  localparam logic [2:0] FK_CY_HI  = 3'd3;
  localparam logic [2:0] FK_TABLE  = 3'd4;

  localparam logic [1:0] CM_SUB_A = 2'b00;
  localparam logic [1:0] CM_SUB_B = 2'b01;
endpackage

// File: rtl/sca_cell.sv
module sca_cell
  import sca_pkg::*;
(
  input  logic        x,
  input  logic        y,
  input  logic        ci,
  input  logic        fault_on,
  input  logic [2:0]  kind,
  input  logic [15:0] tbl,
  output logic        s,
  output logic        co
);
  logic [2:0] idx;
  assign idx = {x, y, ci};

  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
    if (fault_on) begin
      case (kind)
        FK_SUM_LO: s  = 1'b0;
        FK_SUM_HI: s  = 1'b1;
        FK_CY_LO:  co = 1'b0;
        FK_CY_HI:  co = 1'b1;
        FK_TABLE: begin
          s  = tbl[{1'b0, idx}];
          co = tbl[{1'b1, idx}];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sca_ripple.sv
module sca_ripple #(
  parameter int W    = 8,
  parameter int IDXW = 3
) (
  input  logic [W-1:0]    x,
  input  logic [W-1:0]    y,
  input  logic            ci,
  input  logic            flt_en,
  input  logic [IDXW-1:0] flt_cell,
  input  logic [2:0]      flt_kind,
  input  logic [15:0]     flt_tbl,
  output logic [W-1:0]    r
);
  logic [W:0] cy;
  logic       unused_cout;

  assign cy[0]       = ci;
  assign unused_cout = cy[W];

  for (genvar g = 0; g < W; g++) begin : g_cell
    logic hit;
    assign hit = flt_en && (int'(flt_cell) == g);
    sca_cell u_cell (
      .x        (x[g]),
      .y        (y[g]),
      .ci       (cy[g]),
      .fault_on (hit),
      .kind     (flt_kind),
      .tbl      (flt_tbl),
      .s        (r[g]),
      .co       (cy[g+1])
    );
  end
endmodule

// File: rtl/sca_seq.sv
module sca_seq
  import sca_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [1:0]   chk_mode,
  output logic [W-1:0] add_x,
  output logic [W-1:0] add_y,
  output logic         add_ci,
  input  logic [W-1:0] add_r,
  output logic [W-1:0] sum,
  output logic         err,
  output logic         done
);
  sca_state_e   st_q, st_d;
  logic [W-1:0] a_q, b_q, s_q;
  logic [1:0]   mode_q;
  logic         err_q;
  logic         both;
  logic         accept;
  logic [W-1:0] ref_v;
  logic         miss;

  assign both   = mode_q[1];
  assign accept = in_valid && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_ADD;
      ST_ADD:  st_d = (mode_q == CM_SUB_B) ? ST_CHKB : ST_CHKA;
      ST_CHKA: st_d = both ? ST_CHKB : ST_DONE;
      ST_CHKB: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    add_x  = s_q;
    add_y  = ~a_q;
    add_ci = 1'b1;
    ref_v  = b_q;
    case (st_q)
      ST_ADD: begin
        add_x  = a_q;
        add_y  = b_q;
        add_ci = 1'b0;
      end
      ST_CHKB: begin
        add_y = ~b_q;
        ref_v = a_q;
      end
      default: ;
    endcase
  end

  assign miss = (add_r != ref_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      s_q    <= '0;
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        a_q    <= in_a;
        b_q    <= in_b;
        mode_q <= chk_mode;
        err_q  <= 1'b0;
      end
      if (st_q == ST_ADD) s_q <= add_r;
      if (st_q == ST_CHKA || st_q == ST_CHKB) err_q <= err_q | miss;
    end
  end

  assign in_ready = (st_q == ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign sum      = s_q;
  assign err      = err_q;
endmodule

// File: rtl/self_check_adder.sv
module self_check_adder #(
  parameter int W    = 8,
  parameter int IDXW = (W > 1) ? $clog2(W) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic [1:0]      chk_mode,
  input  logic            flt_en,
  input  logic [IDXW-1:0] flt_cell,
  input  logic [2:0]      flt_kind,
  input  logic [15:0]     flt_tbl,
  output logic [W-1:0]    sum,
  output logic            err,
  output logic            done
);
  logic [W-1:0] add_x, add_y, add_r;
  logic         add_ci;

  sca_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_a     (in_a),
    .in_b     (in_b),
    .chk_mode (chk_mode),
    .add_x    (add_x),
    .add_y    (add_y),
    .add_ci   (add_ci),
    .add_r    (add_r),
    .sum      (sum),
    .err      (err),
    .done     (done)
  );

  sca_ripple #(.W(W), .IDXW(IDXW)) u_adder (
    .x        (add_x),
    .y        (add_y),
    .ci       (add_ci),
    .flt_en   (flt_en),
    .flt_cell (flt_cell),
    .flt_kind (flt_kind),
    .flt_tbl  (flt_tbl),
    .r        (add_r)
  );
endmodule

// File: rtl/sca_checker.sv
module sca_checker #(
  parameter int W    = 8,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [W-1:0]    in_a,
  input logic [W-1:0]    in_b,
  input logic [1:0]      chk_mode,
  input logic            flt_en,
  input logic [IDXW-1:0] flt_cell,
  input logic [2:0]      flt_kind,
  input logic [15:0]     flt_tbl,
  input logic [W-1:0]    sum,
  input logic            err,
  input logic            done
);
  logic [W-1:0] ea, eb;
  logic         both_q, clean_q;
  logic [3:0]   age;
  logic         unused_in;

  assign unused_in = ^{flt_cell, flt_kind, flt_tbl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea <= '0; eb <= '0; both_q <= 1'b0; clean_q <= 1'b0; age <= '0;
    end else if (in_valid && in_ready) begin
      ea <= in_a; eb <= in_b; both_q <= chk_mode[1];
      clean_q <= !flt_en; age <= 4'd0;
    end else begin
      if (flt_en) clean_q <= 1'b0;
      if (age != 4'hF) age <= age + 4'd1;
    end
  end

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r1_not_ready_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (age == (both_q ? 4'd3 : 4'd2)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(sum) && $stable(err)));
  a_r2_clean_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && clean_q) |-> (sum == W'(ea + eb) && !err));
endmodule

bind self_check_adder sca_checker #(.W(W), .IDXW(IDXW)) u_sca_checker (.*);

// File: tb/test_self_check_adder.sv
module test_self_check_adder;
  localparam int W    = 8;
  localparam int IDXW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [W-1:0]    in_a = '0, in_b = '0;
  logic [1:0]      chk_mode = '0;
  logic            flt_en = 1'b0;
  logic [IDXW-1:0] flt_cell = '0;
  logic [2:0]      flt_kind = '0;
  logic [15:0]     flt_tbl = '0;
  logic [W-1:0]    sum;
  logic            err, done;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  self_check_adder #(.W(W), .IDXW(IDXW)) i_self_check_adder (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fadd(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic ci);
    logic c = ci;
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      logic s0 = x[i] ^ y[i] ^ c;
      logic c0 = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
      int   k  = {x[i], y[i], c};
      if (flt_en && int'(flt_cell) == i) begin
        case (flt_kind)
          3'd0: s0 = 1'b0;
          3'd1: s0 = 1'b1;
          3'd2: c0 = 1'b0;
          3'd3: c0 = 1'b1;
          3'd4: begin s0 = flt_tbl[k]; c0 = flt_tbl[8+k]; end
          default: ;
        endcase
      end
      r[i] = s0;
      c = c0;
    end
    return r;
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] m,
                        input string tag);
    logic [W-1:0] es;
    logic ee;
    int lat, el;
    es = fadd(a, b, 1'b0);
    ee = 1'b0;
    if (m != 2'b01) ee |= (fadd(es, ~a, 1'b1) != b);
    if (m != 2'b00) ee |= (fadd(es, ~b, 1'b1) != a);
    el = m[1] ? 3 : 2;
    @(negedge clk);
    in_a = a; in_b = b; chk_mode = m; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    check({"R1 busy ", tag}, in_ready, 0);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!done && lat < 8);
    check({"R6 latency ", tag}, lat, el);
    check({"R10 sum ", tag}, sum, es);
    check({"R10 err ", tag}, err, ee);
    @(negedge clk);
    check({"R6 done low ", tag}, done, 0);
    check({"R7 hold sum ", tag}, sum, es);
    check({"R7 hold err ", tag}, err, ee);
    check({"R1 ready ", tag}, in_ready, 1);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset sum", sum, 0);
    check("R7 reset err", err, 0);
    check("R6 reset done", done, 0);
    check("R1 reset ready", in_ready, 1);

    // R2: overflow ignored, all modes fault-free
    run_op(8'hFF, 8'h01, 2'b00, "R2 ovf m0");
    check("R2 ovf sum", sum, 0);
    run_op(8'hFF, 8'hFF, 2'b01, "R2 ovf m1");
    check("R2 ovf sum2", sum, 8'hFE);
    run_op(8'h80, 8'h80, 2'b10, "R2 ovf m2");
    check("R2 err", err, 0);
    run_op(8'h12, 8'h34, 2'b11, "R5 m3 clean");
    check("R2 sum", sum, 8'h46);

    // R8: fault disabled has no effect
    flt_kind = 3'd1; flt_cell = 3'd2; flt_en = 1'b0;
    run_op(8'h00, 8'h00, 2'b10, "R8 disabled");
    check("R8 disabled sum", sum, 0);

    // R9: kind 5 is fault-free
    flt_en = 1'b1; flt_kind = 3'd5;
    run_op(8'h5A, 8'hA5, 2'b10, "R9 kind5");
    check("R9 kind5 err", err, 0);

    // R9: sum stuck-1 at cell 2 corrupts sum
    flt_kind = 3'd1;
    run_op(8'h00, 8'h00, 2'b00, "R9 sum hi");
    check("R9 sum stuck hi", sum, 8'h04);

    // R10/R3: correct sum but detected, carry stuck-0 at cell 0
    flt_cell = 3'd0; flt_kind = 3'd2;
    run_op(8'h01, 8'h00, 2'b00, "R3 detect");
    check("R10 correct sum", sum, 8'h01);
    check("R3 detected err", err, 1);
    run_op(8'h01, 8'h00, 2'b01, "R4 detect");
    check("R4 detected err", err, 1);

    // R9: truth-table override equal to a good full adder is fault-free
    flt_kind = 3'd4; flt_tbl = 16'hE896;
    run_op(8'h77, 8'h99, 2'b10, "R9 tbl good");
    check("R9 tbl good err", err, 0);

    // Random sweep: modes R3 R4 R5, faults R8 R9 R10
    for (int n = 0; n < 400; n++) begin
      flt_en   = ($urandom % 4) != 0;
      flt_cell = IDXW'($urandom);
      flt_kind = 3'($urandom);
      flt_tbl  = 16'($urandom);
      run_op(W'($urandom), W'($urandom), 2'($urandom), "rand");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule